// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block is the transmit half of an I2C bus master. A controller above it raises single-cycle request strobes to put a Start, a Repeated Start or a Stop condition on the bus, and it writes one byte at a time into a transmit buffer. Each accepted buffer write starts the clock generator at once. The byte is then sent most significant bit first, and the block collects the slave's acknowledge on the ninth clock. After the ninth clock the block stops in a parked state: SCL is held low, the clock generator is frozen, and the interrupt flag is raised. The block stays parked until the controller writes another byte or asks for a bus condition.

The bus pins are open drain. The block drives two registered "pull low" enables and reads SDA back through a small synchronizer. The length of each SCL phase comes from a reload counter. With reload parameter N, every low phase and every high phase lasts N+1 system clocks, and N must be at least 1. A data-bit change on SDA always happens one system clock after the SCL edge that allows it, which gives the slave a hold margin past each falling edge. The control and status outputs are a buffer-full flag, a sticky write-collision flag, an acknowledge-status flag, an interrupt flag, and one self-clearing pending bit for each kind of bus condition.

Top module: `i2c_tx_master`

## Requirements
- R1: After reset both drive-low enables are 0 (both lines released), and buf_full, wcol, ack_stat, irq and all three pending bits are 0.
- R2: A wr_buf pulse while parked with nothing pending sets buf_full on the next clock and sends wr_data on SDA, bit 7 first. SDA changes only while SCL is low, and never in the same clock as an SCL edge.
- R3: While a byte is sent, each SCL low phase between two bits and each SCL high phase in which a bit is sampled lasts exactly N+1 clocks.
- R4: On the falling SCL edge that ends the eighth bit, buf_full clears, and the master releases SDA one clock later for the acknowledge.
- R5: The level on SDA during the ninth clock is stored in ack_stat: 0 for an acknowledge (SDA low), 1 for a not-acknowledge (SDA high).
- R6: At the falling edge of the ninth clock irq is set. SCL then stays driven low and no further bus activity takes place until the next accepted request or buffer write.
- R7: A wr_buf pulse while a byte is being shifted sets wcol and changes neither the byte on the bus nor the byte count. wcol stays set until a clr_wcol pulse.
- R8: A req_start pulse while the bus is idle sets start_pend. SDA then falls with SCL released, and SCL is pulled low N clocks after SDA falls. At that point start_pend clears and irq is set.
- R9: A req_restart pulse while parked sets restart_pend. The master releases SDA, then releases SCL, then pulls SDA low with SCL high, and pulls SCL low N clocks later. At that point restart_pend clears and irq is set.
- R10: A req_stop pulse while parked sets stop_pend. SCL is released while SDA is held low, and SDA is released N+2 clocks after SCL rises. When the bus returns to idle, stop_pend clears and irq is set.
- R11: req_start, req_restart and req_stop pulses made while a byte is being shifted leave every pending bit at 0 and put no condition on the bus.
- R12: A clr_irq pulse clears irq, and clr_wcol clears wcol. A new interrupt event in the same clock wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_buf | input | 1 | Transmit-buffer write strobe |
| wr_data | input | 8 | Byte to transmit |
| req_start | input | 1 | Request a Start condition |
| req_restart | input | 1 | Request a Repeated Start condition |
| req_stop | input | 1 | Request a Stop condition |
| clr_irq | input | 1 | Clear the interrupt flag |
| clr_wcol | input | 1 | Clear the write-collision flag |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| buf_full | output | 1 | A written byte has not yet been fully shifted out |
| wcol | output | 1 | A buffer write collided with a byte in flight |
| ack_stat | output | 1 | Last acknowledge: 0 ACK, 1 NACK |
| irq | output | 1 | Condition or byte completed |
| start_pend | output | 1 | Start condition in progress |
| restart_pend | output | 1 | Repeated Start in progress |
| stop_pend | output | 1 | Stop condition in progress |

## Verification
A bench-side bus decoder rebuilds Start, Stop and byte events from the pin levels. A design that moved SDA while SCL was high during a data bit would therefore show up as a false Start or Stop, and a design that kept clocking after the ninth bit would produce an event nobody expected. The bench sends a second write into the middle of a byte to show that a design which queued or overwrote the buffer would corrupt the byte on the bus. It also raises stop and restart requests during a shift, which would leave a pending bit set or tear the frame if they were not rejected. The bench measures phase lengths, the Start hold and the Stop setup in clocks, which catches an off-by-one reload or a missing data lag. It also sends both ACK and NACK on the ninth clock, which exposes an inverted or mistimed acknowledge capture.

// File: rtl/i2c_tx_pkg.sv
package i2c_tx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,   // bus free, both lines released
    ST_START,  // SDA low with SCL high
    ST_PARK,   // SCL held low, clock frozen
    ST_BLO,    // data bit, SCL low
    ST_BHI,    // data bit, SCL high
    ST_ALO,    // acknowledge slot, SCL low
    ST_AHI,    // acknowledge slot, SCL high
    ST_RREL,   // repeated start: SDA released, SCL low
    ST_RHI,    // repeated start: both released
    ST_RSDA,   // repeated start: SDA low, SCL high
    ST_PLO,    // stop: SDA low, SCL low
    ST_PHI     // stop: SDA low, SCL high
  } tx_state_e;

  typedef struct packed {
    logic start_done;
    logic restart_done;
    logic stop_done;
    logic byte_sent;
    logic ack_done;
  } tx_evt_t;

endpackage

// File: rtl/i2c_tx_sync.sv
module i2c_tx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;

      always_comb begin
        chain_d = {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0:0], d};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= '1;
        end else begin
          chain_q <= chain_d;
        end
      end

      assign q = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/i2c_tx_brg.sv
module i2c_tx_brg #(
  parameter int RELOAD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int CW = (RELOAD < 1) ? 1 : $clog2(RELOAD + 1);
  localparam logic [CW-1:0] LOADV = CW'(RELOAD);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (!run) begin
      cnt_d = LOADV;
    end else if (cnt_q == '0) begin
      cnt_d = LOADV;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LOADV;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick = run && (cnt_q == '0);

endmodule

// File: rtl/i2c_tx_ctl.sv
module i2c_tx_ctl
  import i2c_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] wr_data,
  input  logic       start_pend,
  input  logic       restart_pend,
  input  logic       stop_pend,
  output logic       run,
  output logic       is_idle,
  output logic       is_park,
  output logic       is_shift,
  output tx_evt_t    evt,
  output logic       scl_lo,
  output logic       sda_lo
);

  tx_state_e  st_q, st_d;
  logic [7:0] sh_q, sh_d;
  logic [2:0] bit_q, bit_d;
  logic       scl_q, scl_d;
  logic       want_q, want_d;
  logic       sda_q;

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    bit_d  = bit_q;
    scl_d  = scl_q;
    want_d = want_q;
    evt    = '0;
    case (st_q)
      ST_IDLE: begin
        if (start_pend) begin
          st_d   = ST_START;
          scl_d  = 1'b0;
          want_d = 1'b1;
        end
      end
      ST_START: begin
        if (tick) begin
          st_d           = ST_PARK;
          scl_d          = 1'b1;
          evt.start_done = 1'b1;
        end
      end
      ST_PARK: begin
        if (load) begin
          st_d   = ST_BLO;
          sh_d   = wr_data;
          bit_d  = 3'd7;
          want_d = ~wr_data[7];
        end else if (restart_pend) begin
          st_d   = ST_RREL;
          want_d = 1'b0;
        end else if (stop_pend) begin
          st_d   = ST_PLO;
          want_d = 1'b1;
        end
      end
      ST_BLO: begin
        if (tick) begin
          st_d  = ST_BHI;
          scl_d = 1'b0;
        end
      end
      ST_BHI: begin
        if (tick) begin
          scl_d = 1'b1;
          if (bit_q == 3'd0) begin
            st_d          = ST_ALO;
            want_d        = 1'b0;
            evt.byte_sent = 1'b1;
          end else begin
            st_d   = ST_BLO;
            sh_d   = {sh_q[6:0], sh_q[7]};
            bit_d  = bit_q - 1'b1;
            want_d = ~sh_q[6];
          end
        end
      end
      ST_ALO: begin
        if (tick) begin
          st_d  = ST_AHI;
          scl_d = 1'b0;
        end
      end
      ST_AHI: begin
        if (tick) begin
          st_d         = ST_PARK;
          scl_d        = 1'b1;
          evt.ack_done = 1'b1;
        end
      end
      ST_RREL: begin
        if (tick) begin
          st_d  = ST_RHI;
          scl_d = 1'b0;
        end
      end
      ST_RHI: begin
        if (tick) begin
          st_d   = ST_RSDA;
          want_d = 1'b1;
        end
      end
      ST_RSDA: begin
        if (tick) begin
          st_d             = ST_PARK;
          scl_d            = 1'b1;
          evt.restart_done = 1'b1;
        end
      end
      ST_PLO: begin
        if (tick) begin
          st_d  = ST_PHI;
          scl_d = 1'b0;
        end
      end
      ST_PHI: begin
        if (tick) begin
          st_d          = ST_IDLE;
          want_d        = 1'b0;
          evt.stop_done = 1'b1;
        end
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      bit_q  <= '0;
      scl_q  <= 1'b0;
      want_q <= 1'b0;
      sda_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      scl_q  <= scl_d;
      want_q <= want_d;
      sda_q  <= want_q;   // data lags the clock edge by one cycle
    end
  end

  assign run      = (st_q != ST_IDLE) && (st_q != ST_PARK);
  assign is_idle  = (st_q == ST_IDLE);
  assign is_park  = (st_q == ST_PARK);
  assign is_shift = (st_q == ST_BLO) || (st_q == ST_BHI) ||
                    (st_q == ST_ALO) || (st_q == ST_AHI);
  assign scl_lo   = scl_q;
  assign sda_lo   = sda_q;

endmodule

// File: rtl/i2c_tx_master.sv
module i2c_tx_master
  import i2c_tx_pkg::*;
#(
  parameter int RELOAD      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_buf,
  input  logic [7:0] wr_data,
  input  logic       req_start,
  input  logic       req_restart,
  input  logic       req_stop,
  input  logic       clr_irq,
  input  logic       clr_wcol,
  input  logic       sda_in,
  output logic       scl_drive_low,
  output logic       sda_drive_low,
  output logic       buf_full,
  output logic       wcol,
  output logic       ack_stat,
  output logic       irq,
  output logic       start_pend,
  output logic       restart_pend,
  output logic       stop_pend
);

  logic    sda_sync;
  logic    run, tick;
  logic    is_idle, is_park, is_shift;
  logic    any_pend, load, collide;
  tx_evt_t evt;

  logic bf_q, bf_d;
  logic wc_q, wc_d;
  logic ak_q, ak_d;
  logic iq_q, iq_d;
  logic sp_q, sp_d;
  logic rp_q, rp_d;
  logic pp_q, pp_d;

  i2c_tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sda_in),
    .q     (sda_sync)
  );

  i2c_tx_brg #(.RELOAD(RELOAD)) u_brg (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick)
  );

  i2c_tx_ctl u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .load         (load),
    .wr_data      (wr_data),
    .start_pend   (sp_q),
    .restart_pend (rp_q),
    .stop_pend    (pp_q),
    .run          (run),
    .is_idle      (is_idle),
    .is_park      (is_park),
    .is_shift     (is_shift),
    .evt          (evt),
    .scl_lo       (scl_drive_low),
    .sda_lo       (sda_drive_low)
  );

  assign any_pend = sp_q || rp_q || pp_q;
  assign load     = wr_buf && is_park && !any_pend;
  assign collide  = wr_buf && is_shift;

  always_comb begin
    bf_d = bf_q;
    if (load) begin
      bf_d = 1'b1;
    end else if (evt.byte_sent) begin
      bf_d = 1'b0;
    end

    wc_d = wc_q;
    if (collide) begin
      wc_d = 1'b1;
    end else if (clr_wcol) begin
      wc_d = 1'b0;
    end

    iq_d = iq_q;
    if (evt.start_done || evt.restart_done || evt.stop_done || evt.ack_done) begin
      iq_d = 1'b1;
    end else if (clr_irq) begin
      iq_d = 1'b0;
    end

    ak_d = evt.ack_done ? sda_sync : ak_q;

    sp_d = sp_q;
    if (evt.start_done) begin
      sp_d = 1'b0;
    end else if (req_start && is_idle && !any_pend) begin
      sp_d = 1'b1;
    end

    rp_d = rp_q;
    if (evt.restart_done) begin
      rp_d = 1'b0;
    end else if (req_restart && is_park && !any_pend && !wr_buf) begin
      rp_d = 1'b1;
    end

    pp_d = pp_q;
    if (evt.stop_done) begin
      pp_d = 1'b0;
    end else if (req_stop && !req_restart && is_park && !any_pend && !wr_buf) begin
      pp_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bf_q <= 1'b0;
      wc_q <= 1'b0;
      ak_q <= 1'b0;
      iq_q <= 1'b0;
      sp_q <= 1'b0;
      rp_q <= 1'b0;
      pp_q <= 1'b0;
    end else begin
      bf_q <= bf_d;
      wc_q <= wc_d;
      ak_q <= ak_d;
      iq_q <= iq_d;
      sp_q <= sp_d;
      rp_q <= rp_d;
      pp_q <= pp_d;
    end
  end

  assign buf_full     = bf_q;
  assign wcol         = wc_q;
  assign ack_stat     = ak_q;
  assign irq          = iq_q;
  assign start_pend   = sp_q;
  assign restart_pend = rp_q;
  assign stop_pend    = pp_q;

endmodule

// File: rtl/i2c_tx_master_chk.sv
module i2c_tx_master_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_buf,
  input logic scl_drive_low,
  input logic sda_drive_low,
  input logic buf_full,
  input logic wcol,
  input logic ack_stat,
  input logic irq,
  input logic start_pend,
  input logic restart_pend,
  input logic stop_pend
);

  // R2: the buffer only fills as a result of a write strobe
  assert_bf_from_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_full) |-> $past(wr_buf));

  // R2: the two lines never move in the same clock
  assert_no_joint_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_drive_low) |-> $stable(sda_drive_low));

  // R4: buf_full drops exactly at a falling SCL edge
  assert_bf_clear_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_full) |-> $rose(scl_drive_low));

  // R5: acknowledge status only moves when a ninth clock ends
  assert_ack_at_ninth_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ack_stat) |-> (irq && $rose(scl_drive_low)));

  // R7: a write during a byte raises the collision flag
  assert_collision_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && wr_buf) |=> wcol);

  // R8: start completes with SCL low and the interrupt raised
  assert_start_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_pend) |-> (irq && scl_drive_low && sda_drive_low));

  // R9: repeated start completes with both lines low and the interrupt raised
  assert_restart_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(restart_pend) |-> (irq && scl_drive_low && sda_drive_low));

  // R10: stop completes with SCL released and the interrupt raised
  assert_stop_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_pend) |-> (irq && !scl_drive_low));

  // R11: no condition is pending while a byte is in flight
  assert_no_pend_in_shift_R11: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !(start_pend || restart_pend || stop_pend));

endmodule

bind i2c_tx_master i2c_tx_master_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_buf        (wr_buf),
  .scl_drive_low (scl_drive_low),
  .sda_drive_low (sda_drive_low),
  .buf_full      (buf_full),
  .wcol          (wcol),
  .ack_stat      (ack_stat),
  .irq           (irq),
  .start_pend    (start_pend),
  .restart_pend  (restart_pend),
  .stop_pend     (stop_pend)
);

// File: tb/i2c_tx_master_tb.sv
module i2c_tx_master_tb;

  localparam int N       = 4;
  localparam int K_START = 0;
  localparam int K_STOP  = 1;
  localparam int K_BYTE  = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       wr_buf, req_start, req_restart, req_stop, clr_irq, clr_wcol;
  logic [7:0] wr_data;
  logic       scl_drive_low, sda_drive_low;
  logic       buf_full, wcol, ack_stat, irq;
  logic       start_pend, restart_pend, stop_pend;
  logic       slv_lo;
  logic       slv_ack_en;
  logic       sda_line;

  assign sda_line = !(sda_drive_low || slv_lo);

  i2c_tx_master #(.RELOAD(N), .SYNC_STAGES(2)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_buf        (wr_buf),
    .wr_data       (wr_data),
    .req_start     (req_start),
    .req_restart   (req_restart),
    .req_stop      (req_stop),
    .clr_irq       (clr_irq),
    .clr_wcol      (clr_wcol),
    .sda_in        (sda_line),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .buf_full      (buf_full),
    .wcol          (wcol),
    .ack_stat      (ack_stat),
    .irq           (irq),
    .start_pend    (start_pend),
    .restart_pend  (restart_pend),
    .stop_pend     (stop_pend)
  );

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    int         kind;
    logic [7:0] data;
    logic       ack;
  } bus_item_t;

  bus_item_t exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_bus(input int k, input logic [7:0] d, input logic a);
    bus_item_t it;
    it.kind = k;
    it.data = d;
    it.ack  = a;
    exp_q.push_back(it);
  endtask

  task automatic seen_bus(input int k, input logic [7:0] d, input logic a,
                          input string req);
    bus_item_t it;
    if (exp_q.size() == 0) begin
      chk(1'b0, req, "unexpected bus event kind", k, -1);
    end else begin
      it = exp_q.pop_front();
      chk(it.kind == k, req, "bus event kind", k, it.kind);
      if (k == K_BYTE && it.kind == K_BYTE) begin
        chk(d == it.data, "R2", "byte on bus", int'(d), int'(it.data));
        chk(a == it.ack, "R5", "ack level on bus", int'(a), int'(it.ack));
      end
    end
  endtask

  // Bus monitor and slave model, sampled on the falling clock edge
  logic       m_scl_p, m_sda_p;
  int         m_lvl, m_bitpos, m_cyc, m_t_start, m_t_rise;
  bit         m_hold_pend, m_sampled;
  logic [8:0] m_sh;

  always @(negedge clk) begin
    logic scl_now;
    logic sda_now;
    scl_now = !scl_drive_low;
    sda_now = sda_line;
    if (!rst_n) begin
      m_scl_p     <= 1'b1;
      m_sda_p     <= 1'b1;
      m_lvl       <= 0;
      m_bitpos    <= 0;
      m_cyc       <= 0;
      m_t_start   <= 0;
      m_t_rise    <= 0;
      m_hold_pend <= 1'b0;
      m_sampled   <= 1'b0;
      m_sh        <= '0;
      slv_lo      <= 1'b0;
    end else begin
      m_cyc <= m_cyc + 1;
      if (scl_now && m_scl_p && (sda_now != m_sda_p)) begin
        if (!sda_now) begin
          seen_bus(K_START, 8'h00, 1'b0, "R8");
          m_t_start   <= m_cyc;
          m_hold_pend <= 1'b1;
        end else begin
          chk(m_cyc - m_t_rise == N + 2, "R10", "stop setup clocks",
              m_cyc - m_t_rise, N + 2);
          seen_bus(K_STOP, 8'h00, 1'b0, "R10");
        end
        m_bitpos  <= 0;
        m_sampled <= 1'b0;
      end else if (scl_now && !m_scl_p) begin
        if (m_bitpos > 0) begin
          chk(m_lvl == N + 1, "R3", "SCL low clocks", m_lvl, N + 1);
        end
        m_t_rise  <= m_cyc;
        m_sampled <= 1'b1;
        if (m_bitpos == 8) begin
          seen_bus(K_BYTE, m_sh[7:0], !sda_now, "R2");
          m_bitpos <= 0;
        end else begin
          m_sh     <= {m_sh[7:0], sda_now};
          m_bitpos <= m_bitpos + 1;
        end
      end else if (!scl_now && m_scl_p) begin
        if (m_hold_pend) begin
          chk(m_cyc - m_t_start == N, "R8", "start hold clocks",
              m_cyc - m_t_start, N);
          m_hold_pend <= 1'b0;
        end
        if (m_sampled) begin
          chk(m_lvl == N + 1, "R3", "SCL high clocks", m_lvl, N + 1);
        end
        m_sampled <= 1'b0;
        slv_lo    <= (m_bitpos == 8) ? slv_ack_en : 1'b0;
      end
      m_lvl   <= (scl_now != m_scl_p) ? 1 : m_lvl + 1;
      m_scl_p <= scl_now;
      m_sda_p <= sda_now;
    end
  end

  task automatic wait_irq();
    while (!irq) @(negedge clk);
  endtask

  task automatic clear_irq();
    @(negedge clk) clr_irq = 1'b1;
    @(negedge clk) clr_irq = 1'b0;
    chk(irq == 1'b0, "R12", "irq after clear", int'(irq), 0);
  endtask

  task automatic do_start();
    expect_bus(K_START, 8'h00, 1'b0);
    @(negedge clk) req_start = 1'b1;
    @(negedge clk) req_start = 1'b0;
    chk(start_pend == 1'b1, "R8", "start_pend after request", int'(start_pend), 1);
    wait_irq();
    chk(start_pend == 1'b0, "R8", "start_pend at completion", int'(start_pend), 0);
    chk(scl_drive_low == 1'b1, "R8", "SCL low after start", int'(scl_drive_low), 1);
    clear_irq();
  endtask

  task automatic do_restart();
    expect_bus(K_START, 8'h00, 1'b0);
    @(negedge clk) req_restart = 1'b1;
    @(negedge clk) req_restart = 1'b0;
    chk(restart_pend == 1'b1, "R9", "restart_pend after request", int'(restart_pend), 1);
    wait_irq();
    chk(restart_pend == 1'b0, "R9", "restart_pend at completion", int'(restart_pend), 0);
    chk(scl_drive_low == 1'b1, "R9", "SCL low after restart", int'(scl_drive_low), 1);
    clear_irq();
  endtask

  task automatic do_stop();
    expect_bus(K_STOP, 8'h00, 1'b0);
    @(negedge clk) req_stop = 1'b1;
    @(negedge clk) req_stop = 1'b0;
    chk(stop_pend == 1'b1, "R10", "stop_pend after request", int'(stop_pend), 1);
    wait_irq();
    chk(stop_pend == 1'b0, "R10", "stop_pend at completion", int'(stop_pend), 0);
    @(negedge clk);
    chk(!scl_drive_low && !sda_drive_low, "R10", "lines released after stop",
        int'({scl_drive_low, sda_drive_low}), 0);
    clear_irq();
  endtask

  task automatic do_byte(input logic [7:0] d, input logic ack, input bit disturb);
    slv_ack_en = ack;
    expect_bus(K_BYTE, d, ack);
    @(negedge clk) begin wr_buf = 1'b1; wr_data = d; end
    @(negedge clk) wr_buf = 1'b0;
    chk(buf_full == 1'b1, "R2", "buf_full after write", int'(buf_full), 1);
    if (disturb) begin
      repeat (12) @(negedge clk);
      wr_data = 8'hFF;
      wr_buf  = 1'b1;
      @(negedge clk) wr_buf = 1'b0;
      chk(wcol == 1'b1, "R7", "wcol after colliding write", int'(wcol), 1);
      req_stop    = 1'b1;
      req_restart = 1'b1;
      req_start   = 1'b1;
      @(negedge clk) begin req_stop = 1'b0; req_restart = 1'b0; req_start = 1'b0; end
      chk(!(stop_pend || restart_pend || start_pend), "R11",
          "pending bits after request in shift",
          int'({start_pend, restart_pend, stop_pend}), 0);
    end
    while (buf_full) @(negedge clk);
    chk(scl_drive_low == 1'b1, "R4", "SCL low when buf_full clears", int'(scl_drive_low), 1);
    @(negedge clk);
    chk(sda_drive_low == 1'b0, "R4", "SDA released for ack", int'(sda_drive_low), 0);
    wait_irq();
    chk(ack_stat == !ack, "R5", "ack_stat", int'(ack_stat), int'(!ack));
    chk(scl_drive_low == 1'b1, "R6", "SCL low at irq", int'(scl_drive_low), 1);
    repeat (4 * (N + 1)) @(negedge clk);
    chk(scl_drive_low == 1'b1 && irq == 1'b1, "R6", "still parked",
        int'({scl_drive_low, irq}), 3);
    if (disturb) begin
      chk(wcol == 1'b1, "R7", "wcol sticky", int'(wcol), 1);
      @(negedge clk) clr_wcol = 1'b1;
      @(negedge clk) clr_wcol = 1'b0;
      chk(wcol == 1'b0, "R12", "wcol after clear", int'(wcol), 0);
    end
    clear_irq();
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n       = 1'b0;
    wr_buf      = 1'b0;
    wr_data     = 8'h00;
    req_start   = 1'b0;
    req_restart = 1'b0;
    req_stop    = 1'b0;
    clr_irq     = 1'b0;
    clr_wcol    = 1'b0;
    slv_ack_en  = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({scl_drive_low, sda_drive_low} == 2'b00, "R1", "lines after reset",
        int'({scl_drive_low, sda_drive_low}), 0);
    chk({buf_full, wcol, ack_stat, irq} == 4'b0, "R1", "flags after reset",
        int'({buf_full, wcol, ack_stat, irq}), 0);
    chk({start_pend, restart_pend, stop_pend} == 3'b0, "R1", "pending after reset",
        int'({start_pend, restart_pend, stop_pend}), 0);

    do_start();
    do_byte(8'hA4, 1'b1, 1'b0);
    do_byte(8'h3C, 1'b0, 1'b0);
    do_byte(8'h5A, 1'b1, 1'b1);
    do_restart();
    do_byte(8'h81, 1'b1, 1'b0);
    do_byte(8'hFF, 1'b0, 1'b0);
    do_byte(8'h00, 1'b1, 1'b0);
    do_stop();
    do_start();
    do_byte(8'h01, 1'b1, 1'b0);
    do_stop();

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R6", "expected bus events left over", exp_q.size(), 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule